// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block is a small direct-mapped table that sits beside a pipeline's fetch stage and guesses, in the same cycle, whether the instruction at the fetch address is a branch that will be taken and where it goes. Each slot holds a valid bit, the upper address bits of a known branch (the tag), the last seen target and a 2-bit saturating confidence counter. A lookup is purely combinational from the fetch address to the prediction outputs. The fetch stage can therefore steer its next address from `pred_next` without an extra cycle.

A later pipeline stage reports each resolved branch on the resolve port: its address, whether it was taken, and its real target. A report that hits its slot moves the counter one step toward the outcome, and a taken report also refreshes the stored target. A taken report that misses claims the slot, evicting any alias that shares the same index. A not-taken report that misses leaves the table alone.

Neither port applies back-pressure. A lookup is answered in the cycle it is presented, and a resolve report is absorbed at the next rising clock edge whenever `rs_valid` is high. Both ports are therefore plain qualified inputs, with no ready signal.

Top module: `btb_predictor`

## Requirements
- R1: After reset every lookup misses: `pred_hit`=0, `pred_taken`=0 and `pred_next` equals `lk_pc`+4.
- R2: A lookup hits only when `lk_valid` is 1 and the slot picked by `lk_pc[5:2]` is valid with a stored tag equal to `lk_pc[31:6]`; with `lk_valid`=0, `pred_hit` and `pred_taken` are 0.
- R3: On a hit, `pred_taken` is bit 1 of the slot's counter (00 and 01 mean not taken; 10 and 11 mean taken). `pred_target` is the stored target. `pred_next` is that target when taken and `lk_pc`+4 otherwise. A miss always predicts not taken.
- R4: A resolve that hits moves the counter up by one on taken and down by one on not taken, saturating at 11 and 00.
- R5: A taken resolve that misses writes the slot with valid=1, the new tag, the reported target and counter 10. A not-taken resolve that misses changes nothing.
- R6: A taken resolve that hits replaces the stored target with `rs_target`.
- R7: From a strongly taken slot (11), a single not-taken outcome leaves the next prediction taken.
- R8: If a lookup and a resolve address the same slot in one cycle, the lookup shows the contents before the update. The update is visible from the next cycle.
- R9: Two branches with the same index and different tags share one slot, and a taken allocation of the second evicts the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all valid bits |
| lk_valid | input | 1 | Fetch lookup qualifier |
| lk_pc | input | 32 | Fetch address being looked up |
| pred_hit | output | 1 | Lookup found a matching valid slot |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_target | output | 32 | Stored target on a hit, zero on a miss |
| pred_next | output | 32 | Predicted next fetch address |
| rs_valid | input | 1 | Resolve report qualifier |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |
| rs_target | input | 32 | Actual branch target |

## Verification
Directed sequences walk one slot through every counter value in both directions. They tell correct saturation and hysteresis (a loop-exit style single reversal) apart from a one-bit history, and a second tag on the same index separates tag comparison from index-only matching. Same-slot lookup/resolve cycles distinguish read-before-write from write-through behaviour, and taken resolves with a changed target show whether the target is refreshed. Random traffic over a small pool of tags and all indices mixes allocations, evictions and counter moves to expose any update that lands on the wrong slot or the wrong condition.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // 2-bit saturating confidence counter; the upper bit is the predicted direction
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_t;

  function automatic logic ctr_predicts_taken(ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/btb_ctr_next.sv
module btb_ctr_next
  import btb_pkg::*;
(
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt
);

  always_comb begin
    nxt = cur;
    unique case (cur)
      CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
      CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
      CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
      CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
      default:       nxt = cur;
    endcase
  end

  // R4
  always_comb begin
    if (cur == CTR_STRONG_T && taken)
      ctr_sat_high_chk: assert (nxt == CTR_STRONG_T);
    if (cur == CTR_STRONG_NT && !taken)
      ctr_sat_low_chk: assert (nxt == CTR_STRONG_NT);
  end

  // R4
  always_comb begin
    if (cur != CTR_STRONG_T && taken)
      ctr_step_up_chk: assert (nxt > cur);
    if (cur != CTR_STRONG_NT && !taken)
      ctr_step_down_chk: assert (nxt < cur);
  end

endmodule

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26,
  parameter int ADDR_W = 32,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // read port A (fetch side)
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_valid,
  output logic [TAG_W-1:0]  a_tag,
  output logic [ADDR_W-1:0] a_tgt,
  output ctr_t              a_ctr,
  // read port B (resolve side)
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_valid,
  output logic [TAG_W-1:0]  b_tag,
  output logic [ADDR_W-1:0] b_tgt,
  output ctr_t              b_ctr,
  // single write port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  ctr_t              wr_ctr
);

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [ADDR_W-1:0] tgt_q [DEPTH];
  ctr_t              ctr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_en && wr_idx == IDX_W'(s)) begin
          tag_q[s] <= wr_tag;
          tgt_q[s] <= wr_tgt;
          ctr_q[s] <= wr_ctr;
        end
      end
    end
  endgenerate

  // reads see the registered contents: a same-cycle write is not forwarded
  assign a_valid = valid_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_tgt   = tgt_q[a_idx];
  assign a_ctr   = ctr_q[a_idx];

  assign b_valid = valid_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_tgt   = tgt_q[b_idx];
  assign b_ctr   = ctr_q[b_idx];

  // R5
  alloc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]);

  // R5
  table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(valid_q));

endmodule

// File: rtl/btb_probe.sv
module btb_probe
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFS_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [ADDR_W-1:0] ent_tgt,
  input  ctr_t              ent_ctr,
  output logic              hit,
  output logic              taken,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] next_pc
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << OFS_W;

  logic [TAG_W-1:0] pc_tag;
  assign pc_tag = pc[ADDR_W-1 -: TAG_W];

  always_comb begin
    hit     = req_valid && ent_valid && (ent_tag == pc_tag);
    taken   = hit && ctr_predicts_taken(ent_ctr);
    target  = hit ? ent_tgt : '0;
    next_pc = taken ? ent_tgt : pc + STEP;
  end

  // R3
  always_comb begin
    if (!hit) miss_not_taken_chk: assert (!taken);
  end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  output logic [ADDR_W-1:0] pred_next,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target
);

  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  logic [IDX_W-1:0]  lk_idx, rs_idx;
  logic              a_valid, b_valid;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [ADDR_W-1:0] a_tgt, b_tgt;
  ctr_t              a_ctr, b_ctr;

  logic              rs_hit, rs_pred_taken;
  logic [ADDR_W-1:0] rs_old_tgt, rs_seq;
  ctr_t              ctr_stepped;

  logic              wr_en;
  ctr_t              wr_ctr;
  logic [ADDR_W-1:0] wr_tgt;

  assign lk_idx = lk_pc[OFS_W +: IDX_W];
  assign rs_idx = rs_pc[OFS_W +: IDX_W];

  btb_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_idx   (lk_idx),
    .a_valid (a_valid),
    .a_tag   (a_tag),
    .a_tgt   (a_tgt),
    .a_ctr   (a_ctr),
    .b_idx   (rs_idx),
    .b_valid (b_valid),
    .b_tag   (b_tag),
    .b_tgt   (b_tgt),
    .b_ctr   (b_ctr),
    .wr_en   (wr_en),
    .wr_idx  (rs_idx),
    .wr_tag  (rs_pc[ADDR_W-1 -: TAG_W]),
    .wr_tgt  (wr_tgt),
    .wr_ctr  (wr_ctr)
  );

  // fetch-side probe
  btb_probe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_fetch_probe (
    .req_valid (lk_valid),
    .pc        (lk_pc),
    .ent_valid (a_valid),
    .ent_tag   (a_tag),
    .ent_tgt   (a_tgt),
    .ent_ctr   (a_ctr),
    .hit       (pred_hit),
    .taken     (pred_taken),
    .target    (pred_target),
    .next_pc   (pred_next)
  );

  // resolve-side probe: only hit and old target are used
  btb_probe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_resolve_probe (
    .req_valid (rs_valid),
    .pc        (rs_pc),
    .ent_valid (b_valid),
    .ent_tag   (b_tag),
    .ent_tgt   (b_tgt),
    .ent_ctr   (b_ctr),
    .hit       (rs_hit),
    .taken     (rs_pred_taken),
    .target    (rs_old_tgt),
    .next_pc   (rs_seq)
  );

  btb_ctr_next u_ctr (
    .cur   (b_ctr),
    .taken (rs_taken),
    .nxt   (ctr_stepped)
  );

  // update policy: train on a hit, allocate only on a taken miss
  always_comb begin
    wr_en  = rs_valid && (rs_hit || rs_taken);
    wr_ctr = rs_hit ? ctr_stepped : CTR_WEAK_T;
    wr_tgt = rs_taken ? rs_target : rs_old_tgt;
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !pred_hit && !pred_taken);

  // R6
  tgt_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && rs_hit) |=> (b_tgt == $past(rs_target)) || (rs_idx != $past(rs_idx)));

  // R7
  hysteresis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit && !rs_taken && b_ctr == CTR_STRONG_T) |=>
      (rs_idx != $past(rs_idx)) || ctr_predicts_taken(b_ctr));

  logic unused_ok;
  assign unused_ok = ^{rs_pred_taken, rs_seq};

endmodule

// File: tb/btb_predictor_test.sv
module btb_predictor_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, rs_valid, rs_taken;
  logic [31:0] lk_pc, rs_pc, rs_target;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_target, pred_next;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench reference table
  bit        m_vld [16];
  bit [25:0] m_tag [16];
  bit [31:0] m_tgt [16];
  bit [1:0]  m_ctr [16];

  always #5 clk = ~clk;

  btb_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken),
    .pred_target(pred_target), .pred_next(pred_next),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target)
  );

  function automatic bit [31:0] mk_pc(input bit [25:0] t, input bit [3:0] i);
    return {t, i, 2'b00};
  endfunction

  function automatic bit [1:0] ctr_step(input bit [1:0] c, input bit tk);
    if (tk) return (c == 2'b11) ? 2'b11 : c + 2'd1;
    return (c == 2'b00) ? 2'b00 : c - 2'd1;
  endfunction

  function automatic bit [65:0] expect_lookup(input bit lv, input bit [31:0] pc);
    bit h, t;
    bit [31:0] tg, nx;
    h  = lv && m_vld[pc[5:2]] && (m_tag[pc[5:2]] == pc[31:6]);
    t  = h && m_ctr[pc[5:2]][1];
    tg = h ? m_tgt[pc[5:2]] : 32'd0;
    nx = t ? m_tgt[pc[5:2]] : pc + 32'd4;
    return {h, t, tg, nx};
  endfunction

  task automatic model_update(input bit rv, input bit [31:0] pc, input bit tk, input bit [31:0] tg);
    bit [3:0] i;
    i = pc[5:2];
    if (!rv) return;
    if (m_vld[i] && m_tag[i] == pc[31:6]) begin
      m_ctr[i] = ctr_step(m_ctr[i], tk);
      if (tk) m_tgt[i] = tg;
    end else if (tk) begin
      m_vld[i] = 1'b1;
      m_tag[i] = pc[31:6];
      m_tgt[i] = tg;
      m_ctr[i] = 2'b10;
    end
  endtask

  // one cycle: drive at negedge, check lookup mid-cycle, update model after the edge
  task automatic step(input bit lv, input bit [31:0] lpc,
                      input bit rv, input bit [31:0] rpc, input bit tk, input bit [31:0] tg,
                      input string req);
    bit [65:0] exp_v, act_v;
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc;
    rs_valid = rv; rs_pc = rpc; rs_taken = tk; rs_target = tg;
    #2;
    exp_v = expect_lookup(lv, lpc);
    act_v = {pred_hit, pred_taken, pred_target, pred_next};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s pc=%h hit/taken/target/next act=%b/%b/%h/%h exp=%b/%b/%h/%h",
               req, lpc, act_v[65], act_v[64], act_v[63:32], act_v[31:0],
               exp_v[65], exp_v[64], exp_v[63:32], exp_v[31:0]);
    end
    @(posedge clk);
    model_update(rv, rpc, tk, tg);
  endtask

  task automatic look(input bit [31:0] pc, input string req);
    step(1'b1, pc, 1'b0, 32'd0, 1'b0, 32'd0, req);
  endtask

  task automatic resolve(input bit [31:0] pc, input bit tk, input bit [31:0] tg, input string req);
    step(1'b0, pc, 1'b1, pc, tk, tg, req);
  endtask

  initial begin
    bit [31:0] pa, pb;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = '0;
    end
    lk_valid = 0; lk_pc = 0; rs_valid = 0; rs_pc = 0; rs_taken = 0; rs_target = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    pa = mk_pc(26'h0001, 4'd5);
    pb = mk_pc(26'h0002, 4'd5);

    // R1: reset state, every slot misses
    for (int i = 0; i < 16; i += 5) look(mk_pc(26'h0001, 4'(i)), "R1");

    // R5: not-taken miss changes nothing, taken miss allocates at weakly taken
    resolve(pa, 1'b0, 32'h0000_4000, "R5");
    look(pa, "R5");
    resolve(pa, 1'b1, 32'h0000_4000, "R5");
    look(pa, "R5");

    // R2: idle lookup on a valid slot stays quiet
    step(1'b0, pa, 1'b0, 32'd0, 1'b0, 32'd0, "R2");

    // R4 / R7: climb to strong, single reversal keeps taken
    resolve(pa, 1'b1, 32'h0000_4000, "R4");
    look(pa, "R4");
    resolve(pa, 1'b0, 32'h0000_4000, "R7");
    look(pa, "R7");
    // R4: descend and saturate low
    resolve(pa, 1'b0, 32'h0000_4000, "R4");
    look(pa, "R4");
    resolve(pa, 1'b0, 32'h0000_4000, "R4");
    resolve(pa, 1'b0, 32'h0000_4000, "R4");
    look(pa, "R4");
    resolve(pa, 1'b1, 32'h0000_4000, "R4");
    look(pa, "R4");
    resolve(pa, 1'b1, 32'h0000_4000, "R4");
    look(pa, "R3");

    // R6: changed target is stored
    resolve(pa, 1'b1, 32'h0000_8800, "R6");
    look(pa, "R6");

    // R8: same slot lookup and resolve in one cycle sees old contents
    step(1'b1, pa, 1'b1, pa, 1'b0, 32'd0, "R8");
    step(1'b1, pa, 1'b1, pa, 1'b0, 32'd0, "R8");
    look(pa, "R8");

    // R9: alias on the same index
    look(pb, "R9");
    resolve(pb, 1'b1, 32'h0000_C000, "R9");
    look(pb, "R9");
    look(pa, "R9");

    // R3: random mix over a small tag pool, all indices
    for (int n = 0; n < 3000; n++) begin
      bit [31:0] lp, rp, tg;
      lp = mk_pc(26'($urandom_range(0, 2)), 4'($urandom_range(0, 15)));
      rp = ($urandom_range(0, 3) == 0) ? lp
           : mk_pc(26'($urandom_range(0, 2)), 4'($urandom_range(0, 15)));
      tg = {20'h0, 10'($urandom_range(0, 7)), 2'b00};
      step(1'($urandom_range(0, 7) != 0), lp, 1'($urandom_range(0, 1)), rp,
           1'($urandom_range(0, 99) < 60), tg, "R3");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the run ended");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule